// File: doc/BRIEF.md
# Linked-List Queue Engine

This block is a small sequencer that manipulates singly linked queues kept in a word-addressed memory. A queue is described by a two-word header: the first word holds the address of the entry at the front of the queue, the second holds the address of the entry at the back. Every entry carries a link word one address below the entry itself. A front pointer of zero means the queue is empty. An empty queue's back pointer holds the address of the header's second word. Because of this, the link update that appends to an empty queue lands on the front word, and appending needs no special case.

The engine accepts three commands: append at the back, insert at the front, and remove from the front. Each command carries a header address and an entry address. It then issues one memory access per clock through a synchronous single-port memory interface with a one-cycle read latency. When the last access is done it pulses `done`. It also reports whether the queue held anything beforehand (`skip`) and, for a removal, which entry came out. All address arithmetic wraps within a 15-bit space.

Top module: `llq_engine`

## Requirements
- R1: Append (command code 1) reads the front and back words at the header address H and H+1. It then writes 0 to the link word of entry E (E-1), writes E to the link word below the old back entry (back-1), and finally writes E to H+1. When the queue was empty, this makes both header words equal to E.
- R2: After an append, `skip` is 1 exactly when the front value read was nonzero.
- R3: Insert-at-front (command code 2) writes the old front value into E-1 and then writes E into H. Only when the old front was zero does it also write E into H+1.
- R4: After an insert-at-front, `skip` is 1 exactly when the old front value was nonzero.
- R5: Remove (command code 3) on a non-empty queue reports the old front F on `deq_entry`, reads the link at F-1, writes that link into H and sets `skip`. When that link is zero, it also writes H+1 into H+1.
- R6: Remove on an empty queue reports 0 on `deq_entry`, leaves `skip` at 0 and writes nothing to memory.
- R7: Every computed address wraps modulo 2^15. Values read from memory are taken from their low 15 bits, and written addresses are zero-extended to the word width.
- R8: The first access after a command is accepted is a read of H, issued in the cycle right after acceptance. At most one access is made per clock, and none while the engine is idle.
- R9: A command (`cmd_valid` with a nonzero code) is accepted only while `busy` is 0. Commands presented while busy, and code 0 at any time, have no effect. `done` is a single-cycle pulse in the cycle after the last access, with `busy` already 0.
- R10: `skip` and `deq_entry` hold their values from the end of a command until the next command is accepted. Both are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Command code: 1 append, 2 insert at front, 3 remove |
| hdr_addr | input | 15 | Queue header address |
| ent_addr | input | 15 | Entry address for append and insert |
| busy | output | 1 | Engine is executing a command |
| done | output | 1 | One-cycle completion pulse |
| skip | output | 1 | Queue was non-empty before the command |
| deq_entry | output | 15 | Entry removed by the last remove command |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |

## Verification
Two things can coincide in one cycle. The first is the completion of one command and the arrival of the next command. The second is a command offered while the engine is mid-sequence. The bench drives a second, different command in the cycle right after acceptance, while the engine is certain to be busy. A reference model of the queue memory, updated only by the accepted command, must then match the whole memory image when `done` rises. The bench also checks that `done` is a lone pulse seen with `busy` low, and that a code-0 request issued while idle starts nothing.

// File: rtl/llq_pkg.sv
package llq_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_APPEND = 2'd1,
    OP_PUSHF  = 2'd2,
    OP_REMOVE = 2'd3
  } llq_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_FRONT,
    ST_RD_BACK,
    ST_A_CLR,
    ST_A_LINK,
    ST_A_BACK,
    ST_P_LINK,
    ST_P_FRONT,
    ST_P_BACK,
    ST_R_CHK,
    ST_R_FRONT,
    ST_R_BACK
  } llq_st_e;
endpackage

// File: rtl/llq_rst_sync.sv
module llq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/llq_ctrl.sv
module llq_ctrl
  import llq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  llq_op_e op_in,
  input  logic    rd_zero,
  input  logic    front_zero,
  output llq_st_e state,
  output logic    done
);
  llq_st_e state_q, state_n;
  llq_op_e op_q, op_n;
  logic    done_n;

  always_comb begin
    op_n = op_q;
    if (start) op_n = op_in;
  end

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:     if (start) state_n = ST_RD_FRONT;
      ST_RD_FRONT: begin
        unique case (op_q)
          OP_APPEND: state_n = ST_RD_BACK;
          OP_PUSHF:  state_n = ST_P_LINK;
          default:   state_n = ST_R_CHK;
        endcase
      end
      ST_RD_BACK:  state_n = ST_A_CLR;
      ST_A_CLR:    state_n = ST_A_LINK;
      ST_A_LINK:   state_n = ST_A_BACK;
      ST_A_BACK:   state_n = ST_IDLE;
      ST_P_LINK:   state_n = ST_P_FRONT;
      ST_P_FRONT:  state_n = front_zero ? ST_P_BACK : ST_IDLE;
      ST_P_BACK:   state_n = ST_IDLE;
      ST_R_CHK:    state_n = rd_zero ? ST_IDLE : ST_R_FRONT;
      ST_R_FRONT:  state_n = rd_zero ? ST_R_BACK : ST_IDLE;
      ST_R_BACK:   state_n = ST_IDLE;
      default:     state_n = ST_IDLE;
    endcase
  end

  assign done_n = (state_q != ST_IDLE) && (state_n == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      done    <= 1'b0;
    end else begin
      state_q <= state_n;
      op_q    <= op_n;
      done    <= done_n;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/llq_path.sv
module llq_path
  import llq_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  llq_st_e       state,
  input  logic [AW-1:0] hdr_in,
  input  logic [AW-1:0] ent_in,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          rd_zero,
  output logic          front_zero,
  output logic          skip,
  output logic [AW-1:0] deq_entry
);
  localparam int PADW = DW - AW;
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] rd_val;
  logic          unused_hi;
  logic [AW-1:0] hdr_q, hdr_n, ent_q, ent_n, front_q, front_n, back_q, back_n;
  logic [AW-1:0] deq_q, deq_n;
  logic          skip_q, skip_n;
  logic [AW-1:0] wval;

  assign rd_val     = mem_rdata[AW-1:0];
  assign unused_hi  = ^mem_rdata[DW-1:AW];
  assign rd_zero    = (rd_val == '0);
  assign front_zero = (front_q == '0);

  always_comb begin
    hdr_n   = hdr_q;
    ent_n   = ent_q;
    front_n = front_q;
    back_n  = back_q;
    skip_n  = skip_q;
    deq_n   = deq_q;
    if (start) begin
      hdr_n  = hdr_in;
      ent_n  = ent_in;
      skip_n = 1'b0;
      deq_n  = '0;
    end
    unique case (state)
      ST_RD_BACK: begin front_n = rd_val; skip_n = !rd_zero; end
      ST_A_CLR:   back_n  = rd_val;
      ST_P_LINK:  begin front_n = rd_val; skip_n = !rd_zero; end
      ST_R_CHK:   begin front_n = rd_val; skip_n = !rd_zero; deq_n = rd_val; end
      default:    ;
    endcase
  end

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = hdr_q;
    wval     = '0;
    unique case (state)
      ST_RD_FRONT: mem_req = 1'b1;
      ST_RD_BACK:  begin mem_req = 1'b1; mem_addr = hdr_q + ONE; end
      ST_A_CLR:    begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = ent_q - ONE; end
      ST_A_LINK:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = back_q - ONE; wval = ent_q; end
      ST_A_BACK:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = hdr_q + ONE; wval = ent_q; end
      ST_P_LINK:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = ent_q - ONE; wval = rd_val; end
      ST_P_FRONT:  begin mem_req = 1'b1; mem_we = 1'b1; wval = ent_q; end
      ST_P_BACK:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = hdr_q + ONE; wval = ent_q; end
      ST_R_CHK:    begin mem_req = !rd_zero; mem_addr = rd_val - ONE; end
      ST_R_FRONT:  begin mem_req = 1'b1; mem_we = 1'b1; wval = rd_val; end
      ST_R_BACK:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = hdr_q + ONE; wval = hdr_q + ONE; end
      default:     ;
    endcase
  end

  assign mem_wdata = {{PADW{1'b0}}, wval};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q   <= '0;
      ent_q   <= '0;
      front_q <= '0;
      back_q  <= '0;
      skip_q  <= 1'b0;
      deq_q   <= '0;
    end else begin
      hdr_q   <= hdr_n;
      ent_q   <= ent_n;
      front_q <= front_n;
      back_q  <= back_n;
      skip_q  <= skip_n;
      deq_q   <= deq_n;
    end
  end

  assign skip      = skip_q;
  assign deq_entry = deq_q;
endmodule

// File: rtl/llq_engine.sv
module llq_engine
  import llq_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] hdr_addr,
  input  logic [AW-1:0] ent_addr,
  output logic          busy,
  output logic          done,
  output logic          skip,
  output logic [AW-1:0] deq_entry,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  logic    rst_n_i;
  llq_st_e state;
  logic    start, rd_zero, front_zero;

  llq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  assign busy  = (state != ST_IDLE);
  assign start = cmd_valid && !busy && (cmd_op != 2'd0);

  llq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_i), .start(start), .op_in(llq_op_e'(cmd_op)),
    .rd_zero(rd_zero), .front_zero(front_zero), .state(state), .done(done)
  );

  llq_path #(.AW(AW), .DW(DW)) u_path (
    .clk(clk), .rst_n(rst_n_i), .start(start), .state(state),
    .hdr_in(hdr_addr), .ent_in(ent_addr), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rd_zero(rd_zero), .front_zero(front_zero), .skip(skip), .deq_entry(deq_entry)
  );
endmodule

// File: rtl/llq_engine_chk.sv
module llq_engine_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [AW-1:0] hdr_addr,
  input logic          busy,
  input logic          done,
  input logic          skip,
  input logic [AW-1:0] deq_entry,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);
  // R8
  first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mem_req && !mem_we && mem_addr == $past(hdr_addr)));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // R9
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_valid) |=> ($stable(skip) && $stable(deq_entry)));
endmodule

bind llq_engine llq_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .hdr_addr(hdr_addr),
  .busy(busy), .done(done), .skip(skip), .deq_entry(deq_entry),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/tb_llq_engine.sv
`timescale 1ns/1ps
module tb_llq_engine;
  logic        clk, rst_n, cmd_valid;
  logic [1:0]  cmd_op;
  logic [14:0] hdr_addr, ent_addr;
  logic        busy, done, skip, mem_req, mem_we;
  logic [14:0] deq_entry, mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  logic        ld_en;
  logic [7:0]  ld_addr;
  logic [15:0] ld_data;
  logic [15:0] mem [256];
  logic [15:0] sh  [256];

  int n_chk = 0;
  int n_bad = 0;

  llq_engine dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .hdr_addr(hdr_addr), .ent_addr(ent_addr), .busy(busy), .done(done),
    .skip(skip), .deq_entry(deq_entry), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  function automatic logic [7:0] ix(input logic [14:0] a);
    return a[7:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [14:0] a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = ix(a); ld_data = d;
    sh[ix(a)] = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic ref_op(input logic [1:0] op, input logic [14:0] h, input logic [14:0] e,
                        output logic sk, output logic [14:0] dq, output string tag);
    logic [14:0] f, b, l;
    sk = 1'b0; dq = '0;
    f = sh[ix(h)][14:0];
    case (op)
      2'd1: begin
        b = sh[ix(h + 15'd1)][14:0];
        sh[ix(e - 15'd1)] = 16'h0;
        sh[ix(b - 15'd1)] = {1'b0, e};
        sh[ix(h + 15'd1)] = {1'b0, e};
        sk = (f != 0); tag = "R1";
      end
      2'd2: begin
        sh[ix(e - 15'd1)] = {1'b0, f};
        sh[ix(h)] = {1'b0, e};
        if (f == 0) sh[ix(h + 15'd1)] = {1'b0, e};
        sk = (f != 0); tag = "R3";
      end
      default: begin
        if (f == 0) tag = "R6";
        else begin
          l = sh[ix(f - 15'd1)][14:0];
          sh[ix(h)] = {1'b0, l};
          if (l == 0) sh[ix(h + 15'd1)] = {1'b0, h + 15'd1};
          sk = 1'b1; dq = f; tag = "R5";
        end
      end
    endcase
  endtask

  task automatic cmp_mem(input string tag);
    int bad_i = -1;
    for (int i = 0; i < 256; i++) if (mem[i] !== sh[i] && bad_i < 0) bad_i = i;
    if (bad_i < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, {tag, " memory word"}, int'(mem[bad_i]), int'(sh[bad_i]));
  endtask

  task automatic run_op(input logic [1:0] op, input logic [14:0] h, input logic [14:0] e,
                        input bit inject);
    logic sk_e; logic [14:0] dq_e; string tag; string sk_tag;
    int n;
    ref_op(op, h, e, sk_e, dq_e, tag);
    sk_tag = (op == 2'd1) ? "R2" : (op == 2'd2) ? "R4" : tag;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; hdr_addr = h; ent_addr = e;
    @(negedge clk);
    chk(busy && mem_req && !mem_we && mem_addr == h, "R8 first access", int'(mem_addr), int'(h));
    if (inject) begin
      cmd_op = 2'd3; hdr_addr = 15'h0020; ent_addr = 15'h0045;
    end else cmd_valid = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!done && n < 40) begin @(negedge clk); n++; end
    chk(done === 1'b1, "R9 done seen", int'(done), 1);
    chk(!busy, "R9 idle at done", int'(busy), 0);
    chk(skip === sk_e, sk_tag, int'(skip), int'(sk_e));
    chk(deq_entry === dq_e, tag, int'(deq_entry), int'(dq_e));
    cmp_mem(inject ? "R9 busy command ignored" : tag);
    @(negedge clk);
    chk(!done, "R9 done single pulse", int'(done), 0);
    @(negedge clk);
    chk(skip === sk_e && deq_entry === dq_e, "R10 result held", int'(deq_entry), int'(dq_e));
  endtask

  logic [14:0] qh [3];

  initial begin
    #(200000 * 4);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    qh[0] = 15'h0010; qh[1] = 15'h0020; qh[2] = 15'h0030;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; hdr_addr = '0; ent_addr = '0;
    ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    for (int i = 0; i < 256; i++) poke(15'(i), 16'h0);
    for (int q = 0; q < 3; q++) poke(qh[q] + 15'd1, {1'b0, qh[q] + 15'd1});
    poke(15'h0000, 16'h0000);
    repeat (2) @(negedge clk);
    chk(!busy && !done && !skip && deq_entry == 0 && !mem_req, "R10 reset state",
        int'({busy, done, skip, mem_req}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_op(2'd3, qh[0], 15'h0, 1'b0);
    run_op(2'd1, qh[0], 15'h0041, 1'b0);
    run_op(2'd1, qh[0], 15'h0043, 1'b0);
    run_op(2'd2, qh[0], 15'h0045, 1'b1);
    run_op(2'd3, qh[0], 15'h0, 1'b0);
    run_op(2'd3, qh[0], 15'h0, 1'b0);
    run_op(2'd3, qh[0], 15'h0, 1'b0);
    run_op(2'd3, qh[0], 15'h0, 1'b0);
    run_op(2'd2, qh[1], 15'h0047, 1'b0);
    run_op(2'd2, qh[1], 15'h0049, 1'b0);

    // R7: header at the top of the space; H+1 wraps to 0
    poke(15'h7FFF, 16'h0);
    run_op(2'd1, 15'h7FFF, 15'h0061, 1'b0);
    chk(mem[8'hFF] == 16'h0061 && mem[8'h00] == 16'h0061, "R7 wrap header",
        int'(mem[8'h00]), 16'h0061);
    run_op(2'd3, 15'h7FFF, 15'h0, 1'b0);
    chk(mem[8'h00] == 16'h0000, "R7 wrap back reset", int'(mem[8'h00]), 0);

    // R9: code 0 starts nothing
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; hdr_addr = qh[2];
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!busy && !mem_req, "R9 code zero ignored", int'(busy), 0);
    @(negedge clk);
    chk(!busy && !done, "R9 code zero no done", int'(done), 0);

    for (int k = 0; k < 80; k++) begin
      logic [1:0] op;
      op = 2'(1 + ($urandom % 3));
      run_op(op, qh[$urandom % 3], 15'h0041 + 15'(2 * ($urandom % 31)), ($urandom % 4) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule